// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block holds the digital control for a 10-bit successive-approximation converter. A start pulse opens a conversion. The block holds the sample/hold enable for the first step. It then tries each result bit in turn, from the most significant bit down, by placing a trial code on a bus that feeds an external DAC. A one-bit comparator input tells the block whether to keep each bit or to clear it. When the frame ends, the block shows the finished code and raises a done pulse for one cycle.

The steps do not run on a derived clock. A prescaler counts system clocks and gives a one-cycle step enable every 2^k clocks, where k comes from a 3-bit select. Every conversion is a frame of 13 steps: one sample step, ten bit trials, one step that stores the result, and one closing step. With a 16 MHz system clock and divide-by-128, each step lasts 8 us and the whole conversion lasts 104 us. With divide-by-16, the conversion lasts 13 us.

Top module: `sar_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears `busy`, `sample_hold`, `dac_code`, `result` and `done` to zero, and these outputs stay zero until a start is accepted.
- R2: The select value `div_sel` = k, for k from 1 to 7, sets a step length of 2^k system clocks. The value 0 sets a step length of 2. `done` goes high exactly 13 × step-length clocks after the edge that accepts the start.
- R3: `sample_hold` is high for exactly one step length, starting in the cycle after the start is accepted. It is low at every other time.
- R4: `dac_code` reads 0 during the sample step. When trial step j begins (j = 1..10), `dac_code` holds the bits already decided above bit 10−j, with bit 10−j set to 1 and all lower bits at 0.
- R5: At the end of each trial step, the block samples `cmp_below`. A value of 1 means the input is below the DAC level, and the bit under trial is cleared. A value of 0 keeps the bit. With an ideal comparator for an input code V (0..1023), `result` equals V when `done` rises.
- R6: `busy` is high from the cycle after an accepted start up to the cycle before `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R7: A start pulse that arrives while `busy` is high has no effect on the timing or on the result.
- R8: The block samples `div_sel` only when it accepts a start. Changing `div_sel` during a conversion does not change that conversion's step length.
- R9: `result` holds its value at all times except at the end of the result-storing step of a conversion.
- R10: Under the default case of a 16 MHz system clock and divide-by-128 (`div_sel` = 7), a conversion takes 1664 system clocks, which is 104 us. Divide-by-16 (`div_sel` = 4) gives 208 clocks, which is 13 us.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Requests a conversion. Accepted only while idle |
| div_sel | input | 3 | Prescaler select: k gives divide-by-2^k, and 0 gives divide-by-2 |
| cmp_below | input | 1 | Comparator: 1 when the analog input is below the DAC level |
| busy | output | 1 | High while a conversion runs |
| sample_hold | output | 1 | Sample/hold enable during the first step |
| dac_code | output | 10 | Trial code sent to the external DAC |
| result | output | 10 | Last completed conversion result |
| done | output | 1 | One-cycle pulse when a conversion completes |

## Verification
The hardest case to reach from the ports is a long, slow conversion in which the select value changes and a second start arrives partway through. That conversion must keep its original step length. The bench reaches this case by changing `div_sel` a few cycles after the start, and by pulsing `start` in the middle of the frame at large divide values. It then checks the exact cycle of `done` and the final code. The bench models the comparator from the live `dac_code` against a chosen input value. This lets a sweep over all 1024 input codes drive every keep-or-clear pattern through the trial sequence.

// File: rtl/sar_pkg.sv
package sar_pkg;

  typedef enum logic [1:0] {
    K_SAMPLE,
    K_TRIAL,
    K_STORE,
    K_CLOSE
  } step_kind_t;

  function automatic step_kind_t kind_of(input int step, input int res_w);
    if (step == 0)              return K_SAMPLE;
    else if (step <= res_w)     return K_TRIAL;
    else if (step == res_w + 1) return K_STORE;
    else                        return K_CLOSE;
  endfunction

endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             step_en
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0] sel_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;
  logic [SEL_W-1:0] eff;

  always_comb begin
    eff   = (sel_q == '0) ? SEL_W'(1) : sel_q;
    limit = {CNT_W{1'b1}} >> (CNT_W - int'(eff));
  end

  assign step_en = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      sel_q <= div_sel;
      cnt_q <= '0;
    end else if (!run || step_en) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R2: a step lasts at least two clocks, so two enables never come back to back
  assert_enable_spacing_R2: assert property (@(posedge clk) disable iff (rst)
    step_en |=> !step_en);
  // R8: the latched select does not move while a conversion runs
  assert_select_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> $stable(sel_q));

endmodule

// File: rtl/sar_step_ctrl.sv
module sar_step_ctrl #(
  parameter int RES_W  = 10,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              step_en,
  output logic              load,
  output logic              busy,
  output logic [STEP_W-1:0] step,
  output logic              done
);
  localparam int LAST = RES_W + 2;

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      step <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy <= 1'b1;
        step <= '0;
      end else if (busy && step_en) begin
        if (int'(step) == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
          step <= '0;
        end else begin
          step <= step + 1'b1;
        end
      end
    end
  end

  // R6: done is a single-cycle pulse and never overlaps busy
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: an accepted start always leads to a running frame
  assert_start_accept_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> busy);
  // R2: the frame counter never passes its last step
  assert_step_bound_R2: assert property (@(posedge clk) disable iff (rst)
    int'(step) <= LAST);

endmodule

// File: rtl/sar_bit_engine.sv
module sar_bit_engine
  import sar_pkg::*;
#(
  parameter int RES_W  = 10,
  parameter int STEP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step_en,
  input  logic              busy,
  input  logic [STEP_W-1:0] step,
  input  logic              cmp_below,
  output logic              sample_hold,
  output logic [RES_W-1:0]  trial,
  output logic [RES_W-1:0]  result
);
  logic [RES_W-1:0] trial_nx;
  logic [RES_W-1:0] result_nx;
  logic             sh_nx;
  step_kind_t       kind;

  assign kind = kind_of(int'(step), RES_W);

  always_comb begin
    trial_nx  = trial;
    result_nx = result;
    sh_nx     = sample_hold;
    if (load) begin
      trial_nx = '0;
      sh_nx    = 1'b1;
    end else if (step_en) begin
      if (kind == K_SAMPLE) sh_nx = 1'b0;
      if (kind == K_STORE)  result_nx = trial;
      for (int i = 0; i < RES_W; i++) begin
        if (int'(step) == RES_W - i)     trial_nx[i] = ~cmp_below;
        if (int'(step) == RES_W - 1 - i) trial_nx[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      trial       <= '0;
      result      <= '0;
      sample_hold <= 1'b0;
    end else begin
      trial       <= trial_nx;
      result      <= result_nx;
      sample_hold <= sh_nx;
    end
  end

  // R3: sample/hold only while a conversion runs
  assert_hold_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    sample_hold |-> busy);
  // R9: result is frozen while idle
  assert_result_held_R9: assert property (@(posedge clk) disable iff (rst)
    !busy |=> $stable(result));

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int RES_W = 10,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             cmp_below,
  output logic             busy,
  output logic             sample_hold,
  output logic [RES_W-1:0] dac_code,
  output logic [RES_W-1:0] result,
  output logic             done
);
  localparam int STEP_W = $clog2(RES_W + 3);

  logic              load;
  logic              step_en;
  logic [STEP_W-1:0] step;

  sar_prescaler #(.SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst(rst), .load(load), .run(busy),
    .div_sel(div_sel), .step_en(step_en)
  );

  sar_step_ctrl #(.RES_W(RES_W), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .step_en(step_en),
    .load(load), .busy(busy), .step(step), .done(done)
  );

  sar_bit_engine #(.RES_W(RES_W), .STEP_W(STEP_W)) u_bits (
    .clk(clk), .rst(rst), .load(load), .step_en(step_en), .busy(busy),
    .step(step), .cmp_below(cmp_below), .sample_hold(sample_hold),
    .trial(dac_code), .result(result)
  );

  // R4: the DAC code is cleared when a conversion begins
  assert_code_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (dac_code == '0));

endmodule

// File: tb/sar_sequencer_bench.sv
module sar_sequencer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] div_sel = 3'd1;
  logic       cmp_below;
  logic       busy, sample_hold, done;
  logic [9:0] dac_code, result;
  int         vin = 0;
  int         n_cmp = 0;
  int         n_bad = 0;
  bit         finished = 1'b0;

  always #5 clk = ~clk;

  assign cmp_below = (vin < int'(dac_code));

  sar_sequencer u_sar_sequencer (
    .clk(clk), .rst(rst), .start(start), .div_sel(div_sel),
    .cmp_below(cmp_below), .busy(busy), .sample_hold(sample_hold),
    .dac_code(dac_code), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Runs one conversion; disturb adds a mid-frame select change and start pulse
  task automatic convert(input int sel, input int v, input bit disturb);
    int div = (sel == 0) ? 2 : (1 << sel);
    int total = 13 * div;
    int exp_code = 0;
    @(negedge clk);
    vin = v; div_sel = 3'(sel); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k <= total + 1; k++) begin
      if (disturb && k == 3) div_sel = 3'(7 - sel);
      if (disturb && k == 5 * div) start = 1'b1;
      if (disturb && k == 5 * div + 1) start = 1'b0;
      if (k == div - 1) chk(sample_hold == 1'b1, "R3", int'(sample_hold), 1);
      if (k == div)     chk(sample_hold == 1'b0, "R3", int'(sample_hold), 0);
      if (k == 0)       chk(dac_code == 10'd0, "R4", int'(dac_code), 0);
      for (int j = 1; j <= 10; j++) begin
        if (k == j * div) begin
          int b = 10 - j;
          int hi = (v >> (b + 1)) << (b + 1);
          chk(int'(dac_code) == (hi | (1 << b)), "R4", int'(dac_code), hi | (1 << b));
        end
      end
      if (k == total - 1) begin
        chk(busy == 1'b1 && done == 1'b0, "R6", {busy, done}, 2);
        exp_code = v;
      end
      if (k == total) begin
        chk(done == 1'b1, disturb ? "R7/R8 R2" : "R2", int'(done), 1);
        chk(busy == 1'b0, "R6", int'(busy), 0);
        chk(int'(result) == exp_code, "R5", int'(result), exp_code);
      end
      if (k == total + 1) chk(done == 1'b0, "R6", int'(done), 0);
      if (k < total - 1 && done) chk(1'b0, "R2 early done", k, total);
      @(negedge clk);
    end
    vin = 1023 - v;
    repeat (3) @(negedge clk);
    chk(int'(result) == v, "R9", int'(result), v);
    chk(busy == 1'b0, "R6 idle", int'(busy), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && sample_hold == 0 && done == 0, "R1", {busy, sample_hold, done}, 0);
    chk(dac_code == 0 && result == 0, "R1", int'(dac_code) + int'(result), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 0 && result == 0 && dac_code == 0, "R1 hold", int'(result), 0);
    // R5: all input codes at divide-by-2
    for (int v = 0; v < 1024; v++) convert(1, v, 1'b0);
    // R2: code 0 behaves as divide-by-2, and each other select
    convert(0, 341, 1'b0);
    for (int s = 2; s <= 6; s++) convert(s, 1023 - 37 * s, 1'b0);
    // R10: default 16 MHz / 128 case (1664 clocks) and divide-by-16 (208 clocks)
    convert(7, 600, 1'b0);
    convert(4, 77, 1'b0);
    // R7 and R8: start pulse and select change in mid-conversion
    convert(7, 1, 1'b1);
    convert(2, 1022, 1'b1);
    convert(5, 512, 1'b1);
    // R1: reset in mid-conversion clears everything
    @(negedge clk);
    vin = 700; div_sel = 3'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (40) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(busy == 0 && sample_hold == 0 && dac_code == 0 && result == 0,
        "R1 mid", int'(dac_code), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule